// File: doc/BRIEF.md
# Pulse Timing Probe

The probe measures one pulse of a digital input signal in units of a free-running capture tick. It waits for a start strobe. It then records the tick value at three edges in turn: the first rising edge after the strobe, the falling edge after that, and the next rising edge. From these three stamps it computes the high time and the full period of the waveform. It reports both values together with a one-cycle completion strobe.

A programmable limit bounds each measurement. The input may be stuck or too slow to produce three edges. If the limit expires before the third stamp, the probe ends the measurement and reports zero for both results. The input is asynchronous and passes through a synchronizer before edge detection. All three edges see the same synchronizer delay, so the delay cancels out of the differences. The capture tick is the block clock, and timestamp arithmetic is modulo 2^TICK_W.

Top module: `pulse_probe`

## Requirements
- R1: After reset, `done` is 0 and `high_ticks` and `period_ticks` are 0.
- R2: A measurement begins only on the first rising edge of `sig_in` seen after the start strobe is accepted. A level that is already high, or a falling edge, before that rising edge does not begin it.
- R3: On completion, `high_ticks` equals the clock cycles from that rising edge to the following falling edge. `period_ticks` equals the cycles from that rising edge to the next rising edge, so it is high time plus low time.
- R4: Timestamp differences are taken modulo 2^TICK_W, so a tick counter that wraps inside a measurement still gives correct results.
- R5: If the third edge has not arrived, `done` is high in the cycle that follows the L-th clock edge after the edge that accepted `start`. Here L is `timeout_ticks` sampled at acceptance, and a value of 0 acts as 1. Both outputs are then 0.
- R6: `done` lasts exactly one cycle. `high_ticks` and `period_ticks` change only together with a `done` strobe and hold their values otherwise.
- R7: A start strobe while a measurement is in progress is ignored. It restarts neither the edge sequence nor the limit count.
- R8: Edges on `sig_in` while no measurement is in progress produce no `done` and leave the outputs unchanged.
- R9: With SYNC_STAGES synchronizer flops, `done` rises on the (SYNC_STAGES+1)-th clock edge after the closing rising edge of `sig_in` is sampled high. That is the third cycle boundary for the default of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the capture tick |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe; accepted only when idle |
| timeout_ticks | input | TO_W | Measurement limit in ticks, sampled at start |
| sig_in | input | 1 | Asynchronous signal under measurement |
| done | output | 1 | One-cycle completion strobe |
| high_ticks | output | TICK_W | Measured high time, or 0 after a timeout |
| period_ticks | output | TICK_W | Measured period, or 0 after a timeout |

## Verification
The hardest situations to reach from the ports are the timed corners. One is a timeout that falls after one or two edges have been captured. Another is a second start strobe that arrives halfway through a limit window. The bench drives the signal and `start` on chosen cycles of a counted window, and it checks that `done` appears on exactly the L-th cycle and not earlier. Counter wraparound would take billions of cycles to reach in normal use. The bench reaches it by instantiating the probe with a tick seed just below the wrap point, so an early measurement straddles it. Randomized high and low widths from a fixed seed cover the general case, and the narrowest one-cycle pulse is driven on purpose.

// File: rtl/pulse_probe_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pulse timing probe.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package pulse_probe_pkg;
    // Measurement phase: which edge the sequencer is currently armed for.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no measurement in progress
        PH_LEAD  = 2'd1,   // armed for the opening rising edge
        PH_TRAIL = 2'd2,   // armed for the falling edge
        PH_CLOSE = 2'd3    // armed for the closing rising edge
    } phase_t;
endpackage

// File: rtl/probe_edge_sense.sv
`timescale 1ns/1ps
// Synchronizes the asynchronous input through SYNC_STAGES flops and flags
// single-cycle rising and falling edges of the settled level.
// Assumes: the input holds each level for at least one clock cycle.
module probe_edge_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic settled;
    logic last_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        logic q;
        if (g == 0) begin : g_first
            // first stage: sample the raw asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= sig_in;
            end
        end else begin : g_next
            // later stages: shift the level along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign settled = g_stage[SYNC_STAGES-1].q;

    // remember the previous settled level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= settled;
    end

    assign rise = settled & ~last_q;
    assign fall = ~settled & last_q;
endmodule

// File: rtl/probe_tick_base.sv
`timescale 1ns/1ps
// Free-running capture tick counter, wrapping modulo 2^W.
// Assumes: SEED only moves the wrap point; the value has no other meaning.
module probe_tick_base #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] tick
);
    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    // advance the timestamp base every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= SEED;
        else        tick <= tick + STEP;
    end
endmodule

// File: rtl/probe_deadline.sv
`timescale 1ns/1ps
// Counts cycles of a running measurement and flags the cycle whose closing
// edge is the limit-th edge since arming. A zero limit acts as one.
// Assumes: arm and run are never high together.
module probe_deadline #(
    parameter int TO_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            run,
    input  logic [TO_W-1:0] limit_in,
    output logic            expire
);
    localparam logic [TO_W-1:0] ONE = {{(TO_W-1){1'b0}}, 1'b1};

    logic [TO_W-1:0] elapsed_q;
    logic [TO_W-1:0] limit_q;
    logic [TO_W-1:0] elapsed_nx;

    assign elapsed_nx = elapsed_q + ONE;

    // latch the limit at arming and count cycles while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            limit_q   <= ONE;
        end else if (arm) begin
            elapsed_q <= '0;
            limit_q   <= (limit_in == '0) ? ONE : limit_in;
        end else if (run) begin
            elapsed_q <= elapsed_nx;
        end
    end

    assign expire = run && (elapsed_nx == limit_q);
endmodule

// File: rtl/probe_sequencer.sv
`timescale 1ns/1ps
// Walks the rising / falling / rising capture sequence, stamps each edge
// with the tick value, and produces the results and the completion strobe.
// Assumes: rise and fall are single-cycle flags; completion beats expiry.
module probe_sequencer
    import pulse_probe_pkg::*;
#(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rise,
    input  logic              fall,
    input  logic              expire,
    input  logic [TICK_W-1:0] tick,
    output logic              busy,
    output logic              arm,
    output logic              done,
    output logic [TICK_W-1:0] high_ticks,
    output logic [TICK_W-1:0] period_ticks
);
    phase_t            phase_q;
    logic [TICK_W-1:0] stamp_lead_q;
    logic [TICK_W-1:0] stamp_trail_q;
    logic              hit;
    logic              finish;
    logic              abort;

    assign busy = (phase_q != PH_IDLE);
    assign arm  = start && !busy;

    // select the edge the current phase is armed for; polarity flips per phase
    always_comb begin
        unique case (phase_q)
            PH_LEAD:  hit = rise;
            PH_TRAIL: hit = fall;
            PH_CLOSE: hit = rise;
            default:  hit = 1'b0;
        endcase
    end

    assign finish = hit && (phase_q == PH_CLOSE);
    assign abort  = expire && !finish;

    // advance the phase, capture stamps and publish results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q       <= PH_IDLE;
            stamp_lead_q  <= '0;
            stamp_trail_q <= '0;
            done          <= 1'b0;
            high_ticks    <= '0;
            period_ticks  <= '0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                phase_q <= PH_LEAD;
            end else if (abort) begin
                phase_q      <= PH_IDLE;
                done         <= 1'b1;
                high_ticks   <= '0;
                period_ticks <= '0;
            end else if (hit) begin
                unique case (phase_q)
                    PH_LEAD: begin
                        stamp_lead_q <= tick;
                        phase_q      <= PH_TRAIL;
                    end
                    PH_TRAIL: begin
                        stamp_trail_q <= tick;
                        phase_q       <= PH_CLOSE;
                    end
                    PH_CLOSE: begin
                        high_ticks   <= stamp_trail_q - stamp_lead_q;
                        period_ticks <= tick - stamp_lead_q;
                        done         <= 1'b1;
                        phase_q      <= PH_IDLE;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pulse_probe.sv
`timescale 1ns/1ps
// Pulse timing probe top: measures high time and period of one pulse of
// sig_in in clock ticks after a start strobe, bounded by a cycle limit.
// Assumes: clk is the capture tick; sig_in may be asynchronous.
module pulse_probe #(
    parameter int               TICK_W      = 32,
    parameter int               TO_W        = 24,
    parameter int               SYNC_STAGES = 2,
    parameter logic [TICK_W-1:0] TICK_SEED  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TO_W-1:0]   timeout_ticks,
    input  logic              sig_in,
    output logic              done,
    output logic [TICK_W-1:0] high_ticks,
    output logic [TICK_W-1:0] period_ticks
);
    logic              rise;
    logic              fall;
    logic              expire;
    logic              busy;
    logic              arm;
    logic [TICK_W-1:0] tick;

    probe_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_in(sig_in),
        .rise  (rise),
        .fall  (fall)
    );

    probe_tick_base #(.W(TICK_W), .SEED(TICK_SEED)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    probe_deadline #(.TO_W(TO_W)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .run     (busy),
        .limit_in(timeout_ticks),
        .expire  (expire)
    );

    probe_sequencer #(.TICK_W(TICK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rise        (rise),
        .fall        (fall),
        .expire      (expire),
        .tick        (tick),
        .busy        (busy),
        .arm         (arm),
        .done        (done),
        .high_ticks  (high_ticks),
        .period_ticks(period_ticks)
    );
endmodule

// File: rtl/pulse_probe_chk.sv
`timescale 1ns/1ps
// Protocol checker for the pulse timing probe, bound to the top module.
// Assumes: busy is the top's internal measurement-in-progress flag.
module pulse_probe_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] high_ticks,
    input logic [W-1:0] period_ticks
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(high_ticks) && $stable(period_ticks))); // R6

    AST_ZERO_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((high_ticks == '0) == (period_ticks == '0))); // R5

    AST_HIGH_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && period_ticks != '0) |-> (high_ticks < period_ticks)); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !done); // R8
endmodule

bind pulse_probe pulse_probe_chk #(.W(TICK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .high_ticks  (high_ticks),
    .period_ticks(period_ticks)
);

// File: tb/tb_pulse_probe.sv
`timescale 1ns/1ps
// Self-checking bench for pulse_probe: directed corners plus seeded random
// pulse widths, with expected values computed by bench functions.
module tb_pulse_probe;
    localparam int TICK_W = 32;
    localparam int TO_W   = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [TO_W-1:0]   timeout_ticks;
    logic              sig_in;
    logic              done;
    logic [TICK_W-1:0] high_ticks;
    logic [TICK_W-1:0] period_ticks;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pulse_probe #(
        .TICK_W(TICK_W), .TO_W(TO_W), .SYNC_STAGES(2),
        .TICK_SEED(32'hFFFF_FF80)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_ticks(timeout_ticks),
        .sig_in(sig_in), .done(done), .high_ticks(high_ticks),
        .period_ticks(period_ticks)
    );

    function automatic logic [31:0] exp_high(int h);
        return 32'(h);
    endfunction

    function automatic logic [31:0] exp_period(int h, int l);
        return 32'(h + l);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // full measurement: delay d, high h cycles, low l cycles, closing rise
    task automatic measure(int d, int h, int l, string req);
        drive_start();
        repeat (d) @(negedge clk);
        sig_in = 1'b1;
        repeat (h) @(negedge clk);
        sig_in = 1'b0;
        repeat (l) @(negedge clk);
        sig_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 done not early", done, 0);
        @(negedge clk);
        chk("R9 done on third cycle", done, 1);
        chk({req, " high"}, high_ticks, exp_high(h));
        chk({req, " period"}, period_ticks, exp_period(h, l));
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        sig_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // limit run: optional rise/fall/restart at cycle positions (0 = none)
    task automatic run_limit(int prog, int eff, int rise_at, int fall_at,
                             int restart_at, string req);
        int early;
        early = 0;
        timeout_ticks = TO_W'(prog);
        drive_start();
        for (int j = 1; j <= eff; j++) begin
            @(negedge clk);
            if (j < eff && done) early++;
            if (j == eff) begin
                chk({req, " done at limit"}, done, 1);
                chk({req, " zero high"}, high_ticks, 0);
                chk({req, " zero period"}, period_ticks, 0);
            end
            if (j == rise_at) sig_in = 1'b1;
            if (j == fall_at) sig_in = 1'b0;
            start = (j == restart_at);
        end
        chk({req, " no early done"}, 32'(early), 0);
        start = 1'b0;
        sig_in = 1'b0;
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        repeat (5) @(negedge clk);
        timeout_ticks = TO_W'(1000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int quiet;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; sig_in = 1'b0;
        timeout_ticks = TO_W'(1000);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", done, 0);
        chk("R1 reset high", high_ticks, 0);
        chk("R1 reset period", period_ticks, 0);

        // tick counter wraps during this measurement (seed near the top)
        repeat (100) @(negedge clk);
        measure(0, 20, 20, "R4 wrap");

        // idle edges: no done, results held
        quiet = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            sig_in = ~sig_in;
            if (done) quiet++;
        end
        sig_in = 1'b0;
        repeat (4) @(negedge clk);
        if (done) quiet++;
        chk("R8 idle edges no done", 32'(quiet), 0);
        chk("R8 idle high held", high_ticks, 32'd20);
        chk("R6 period held", period_ticks, 32'd40);

        // level already high at start, then a fall before the first rise
        sig_in = 1'b1;
        repeat (6) @(negedge clk);
        drive_start();
        repeat (5) @(negedge clk);
        sig_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 no done before first rise", done, 0);
        sig_in = 1'b1;
        repeat (9) @(negedge clk);
        sig_in = 1'b0;
        repeat (4) @(negedge clk);
        sig_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 done not early", done, 0);
        @(negedge clk);
        chk("R2 done", done, 1);
        chk("R2 high", high_ticks, exp_high(9));
        chk("R2 period", period_ticks, exp_period(9, 4));
        @(negedge clk);
        sig_in = 1'b0;
        repeat (5) @(negedge clk);

        // narrowest pulse
        measure(3, 1, 1, "R3 minimum");

        // random widths
        for (int i = 0; i < 25; i++) begin
            int d;
            int h;
            int l;
            d = $urandom_range(0, 10);
            h = $urandom_range(1, 60);
            l = $urandom_range(1, 60);
            measure(d, h, l, "R3 random");
        end

        // limit expires after two captured edges
        run_limit(40, 40, 3, 10, 0, "R5 partial");
        // non-zero result, then limit expiry with no edges clears it
        measure(2, 7, 5, "R3 before expiry");
        run_limit(25, 25, 0, 0, 0, "R5 no edges");
        // zero limit acts as one
        run_limit(0, 1, 0, 0, 0, "R5 zero limit");
        // second start mid-run neither restarts the count nor the sequence
        run_limit(30, 30, 0, 0, 10, "R7 restart ignored");
        run_limit(30, 30, 4, 12, 15, "R7 restart ignored after edges");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule